// File: doc/BRIEF.md
# Timer Channel with Capture, Compare and PWM

This block is one channel of a timer peripheral. A single 16-bit holding register does one of three jobs, chosen by a 4-bit mode field in the control register. It can latch a free-running timer value when an external pin changes. It can act as a reference that the timer is matched against, to drive a pin or raise a flag. In PWM mode a separate 10-bit duty value is used instead.

Software writes the mode, the holding register and the duty through a small byte-wide register port. It reads them back through the same port, and it clears the event flag by writing to a status location.

The channel drives one output pin with an enable and one sticky event flag. The 16-bit timer, the 8-bit period timer and its wrap strobe come from outside. The channel only observes them.

The register map uses a 3-bit address:
- 0 is control. Bits 3:0 hold the mode. Bits 5:4 hold the low duty bits. Bits 7:6 read as zero.
- 1 and 2 are the low and high bytes of the holding register.
- 3 is the upper eight duty bits.
- 4 is status. Bit 0 is the flag, and writing 1 to it clears the flag.

Top module: `tcc_channel`

## Requirements
- R1: After reset the control, holding, duty and status locations read 0, and `pin_out`, `pin_oe` and `irq_flag` are 0.
- R2: Mode 0000 turns the channel off. It clears the capture edge count and the compare output latch. Codes 0001, 0011 and 1011 leave the channel inert: no capture, no flag, and `pin_oe` low.
- R3: The pin is passed through two synchronising flops. Mode 0100 copies the timer into the holding register on each falling pin edge, and mode 0101 does so on each rising edge. Each capture sets the flag.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Any change of mode restarts the edge count.
- R5: Mode 0010 inverts the output latch once each time the timer becomes equal to the holding register. It also sets the flag. A timer that stays equal for several cycles counts as one match.
- R6: Entering mode 1000 forces the latch to 0, and a match then sets it to 1. Entering mode 1001 forces the latch to 1, and a match then clears it. Both modes set the flag on a match.
- R7: Mode 1010 sets only the flag on a match. `pin_oe` stays low and `pin_out` stays 0.
- R8: A mode with bits 3:2 equal to 11 selects PWM, with duty = {duty register, control bits 5:4}. The pin rises in the clock after the period wrap strobe and stays high for exactly duty clocks. A duty of 0 keeps it low. A duty of at least the period length in clocks keeps it high.
- R9: A duty written during a period takes effect only at the next wrap.
- R10: Control bits 7:6 read as 0. Control bits 5:4 read back as written and have no effect outside PWM.
- R11: The flag stays set until software writes 1 to status bit 0. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_cnt | input | 16 | Free-running timer value for capture and compare |
| per_cnt | input | 8 | Period timer value, advancing once per four clocks |
| per_wrap | input | 1 | High for the clock in which the period timer wraps to zero |
| pin_in | input | 1 | External pin, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| pin_out | output | 1 | Channel pin level |
| pin_oe | output | 1 | Channel pin drive enable |
| irq_flag | output | 1 | Sticky event flag |

## Verification
The edge count of the prescaler cannot be seen directly. If it is wrong after a mode change, the capture lands one or more edges too early or too late, and that shows up in the holding register as the timer value of a different edge. The next readback after the expected capture edge exposes it.

A stale compare latch shows on `pin_out` within two clocks of the next match. It is checked by entering a forcing mode from the opposite level, and by turning the channel off before a toggle.

A duty buffer that is not double-buffered changes the high time within the same period. A mid-period sample catches this before the next wrap.

// File: rtl/tcc_pkg.sv
// Shared mode codes, register addresses and mode classification helpers
// for the timer capture/compare/PWM channel.
package tcc_pkg;

    typedef logic [3:0] mode_t;

    localparam mode_t MODE_OFF        = 4'b0000;
    localparam mode_t MODE_CMP_TOGGLE = 4'b0010;
    localparam mode_t MODE_CAP_FALL   = 4'b0100;
    localparam mode_t MODE_CAP_RISE   = 4'b0101;
    localparam mode_t MODE_CAP_RISE4  = 4'b0110;
    localparam mode_t MODE_CAP_RISE16 = 4'b0111;
    localparam mode_t MODE_CMP_SET    = 4'b1000;
    localparam mode_t MODE_CMP_CLEAR  = 4'b1001;
    localparam mode_t MODE_CMP_NOTIFY = 4'b1010;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_VAL_LO = 3'd1;
    localparam logic [2:0] ADDR_VAL_HI = 3'd2;
    localparam logic [2:0] ADDR_DUTY   = 3'd3;
    localparam logic [2:0] ADDR_STAT   = 3'd4;

    // True for the four capture codes.
    function automatic logic is_capture(mode_t m);
        return m[3:2] == 2'b01;
    endfunction

    // True for the four PWM codes.
    function automatic logic is_pwm(mode_t m);
        return m[3:2] == 2'b11;
    endfunction

    // True for the compare codes.
    function automatic logic is_compare(mode_t m);
        return (m == MODE_CMP_TOGGLE) || (m == MODE_CMP_SET) ||
               (m == MODE_CMP_CLEAR)  || (m == MODE_CMP_NOTIFY);
    endfunction

    // True where the channel owns the pin driver.
    function automatic logic drives_pin(mode_t m);
        return (m == MODE_CMP_TOGGLE) || (m == MODE_CMP_SET) ||
               (m == MODE_CMP_CLEAR)  || is_pwm(m);
    endfunction

endpackage

// File: rtl/tcc_pin_sync.sv
// Pin synchroniser and edge detector.
// Brings an asynchronous pin into the clock domain through STAGES flops.
// It keeps one more flop of history and flags single-cycle rising and
// falling edges. It assumes the pin holds each level for at least one clock.
module tcc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] shift_q;

    // Shift the pin through the synchroniser and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], pin_i};
    end

    assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];
    assign fall_o = ~shift_q[STAGES-1] & shift_q[STAGES];
endmodule

// File: rtl/tcc_capture.sv
// Capture event generator.
// Turns synchronised pin edges into capture strobes according to the mode.
// For the prescaled modes it counts rising edges and strobes on the last
// edge of each group. The count restarts whenever clr_i is high or the
// mode is not a prescaled one.
module tcc_capture
    import tcc_pkg::*;
#(
    parameter int SHORT_DIV = 4,
    parameter int LONG_DIV  = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode_i,
    input  logic  clr_i,
    input  logic  rise_i,
    input  logic  fall_i,
    output logic  hit_o
);
    localparam int CW = $clog2(LONG_DIV);

    logic [CW-1:0] cnt_q;
    logic          prescaled;
    logic          last;

    assign prescaled = (mode_i == MODE_CAP_RISE4) || (mode_i == MODE_CAP_RISE16);
    assign last      = (mode_i == MODE_CAP_RISE4) ? (cnt_q == CW'(SHORT_DIV - 1))
                                                  : (cnt_q == CW'(LONG_DIV - 1));

    // Count rising edges inside a prescaler group.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clr_i || !prescaled) cnt_q <= '0;
        else if (rise_i)            cnt_q <= last ? '0 : cnt_q + 1'b1;
    end

    // Choose which edge produces a capture.
    always_comb begin
        unique case (mode_i)
            MODE_CAP_FALL:   hit_o = fall_i;
            MODE_CAP_RISE:   hit_o = rise_i;
            MODE_CAP_RISE4,
            MODE_CAP_RISE16: hit_o = rise_i & last & ~clr_i;
            default:         hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcc_compare.sv
// Compare matcher and output latch.
// A match is the first cycle in which the timer equals the reference.
// The output latch is set, cleared or inverted on a match. entry_i marks
// the first cycle of a new mode, and then the forcing modes preset the
// latch instead of reacting to a match. The off mode clears everything.
module tcc_compare
    import tcc_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode_i,
    input  logic             entry_i,
    input  logic [TMR_W-1:0] tmr_i,
    input  logic [TMR_W-1:0] ref_i,
    output logic             hit_o,
    output logic             level_o
);
    logic equal;
    logic equal_q;

    assign equal = (tmr_i == ref_i);
    assign hit_o = is_compare(mode_i) & equal & ~equal_q;

    // Remember last cycle's equality so a held match counts once.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_i == MODE_OFF) equal_q <= 1'b0;
        else                              equal_q <= equal;
    end

    // Update the output latch from the mode entry or a match.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_i == MODE_OFF)            level_o <= 1'b0;
        else if (entry_i && mode_i == MODE_CMP_SET)   level_o <= 1'b0;
        else if (entry_i && mode_i == MODE_CMP_CLEAR) level_o <= 1'b1;
        else if (hit_o) begin
            unique case (mode_i)
                MODE_CMP_TOGGLE: level_o <= ~level_o;
                MODE_CMP_SET:    level_o <= 1'b1;
                MODE_CMP_CLEAR:  level_o <= 1'b0;
                default:         level_o <= level_o;
            endcase
        end
    end
endmodule

// File: rtl/tcc_pwm.sv
// PWM generator.
// It builds a fine-grained count from the external period timer and a
// local FINE_W-bit sub-count, which assumes the period timer steps every
// 2**FINE_W clocks in step with the wrap strobe. The duty is latched at
// each wrap. The output goes high after the wrap and drops when the count
// equals the latched duty.
module tcc_pwm #(
    parameter int PER_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [PER_W-1:0]        per_i,
    input  logic                    wrap_i,
    input  logic [PER_W+FINE_W-1:0] duty_i,
    output logic                    pwm_o
);
    localparam int DUTY_W = PER_W + FINE_W;

    logic [FINE_W-1:0] fine_q;
    logic [FINE_W-1:0] fine_now;
    logic [DUTY_W-1:0] duty_buf_q;
    logic [DUTY_W-1:0] count;

    assign fine_now = wrap_i ? '0 : fine_q;
    assign count    = {per_i, fine_now};

    // Advance the sub-count, realigned at every wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) fine_q <= '0;
        else                 fine_q <= fine_now + 1'b1;
    end

    // Latch the duty at the wrap, then drive the output edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            duty_buf_q <= '0;
            pwm_o      <= 1'b0;
        end else if (wrap_i) begin
            duty_buf_q <= duty_i;
            pwm_o      <= (duty_i != '0);
        end else if (count == duty_buf_q) begin
            pwm_o      <= 1'b0;
        end
    end
endmodule

// File: rtl/tcc_channel.sv
// Timer channel top: register port, holding register, event flag and pin mux.
// The submodules provide capture strobes, compare matches and PWM.
// A mode change is seen one clock after the write, through mode_prev_q.
// Captures take priority over software writes to the holding register.
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int TMR_W  = 16,
    parameter int PER_W  = 8,
    parameter int FINE_W = 2,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] tmr_cnt,
    input  logic [PER_W-1:0] per_cnt,
    input  logic             per_wrap,
    input  logic             pin_in,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq_flag
);
    localparam int DUTY_W = PER_W + FINE_W;
    localparam int DC_LSB = 4;

    mode_t             mode_q, mode_prev_q;
    logic [FINE_W-1:0] dc_lo_q;
    logic [TMR_W-1:0]  cap_val;
    logic [PER_W-1:0]  duty_hi_q;
    logic              mode_chg;
    logic              rise, fall, cap_hit, cmp_hit, cmp_level, pwm_level;
    logic              wr_ctrl, wr_lo, wr_hi, wr_duty, wr_clr;

    assign wr_ctrl  = reg_wr && reg_addr == ADDR_CTRL;
    assign wr_lo    = reg_wr && reg_addr == ADDR_VAL_LO;
    assign wr_hi    = reg_wr && reg_addr == ADDR_VAL_HI;
    assign wr_duty  = reg_wr && reg_addr == ADDR_DUTY;
    assign wr_clr   = reg_wr && reg_addr == ADDR_STAT && reg_wdata[0];
    assign mode_chg = (mode_q != mode_prev_q);

    // Control register: mode and low duty bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_OFF;
            dc_lo_q <= '0;
        end else if (wr_ctrl) begin
            mode_q  <= reg_wdata[3:0];
            dc_lo_q <= reg_wdata[DC_LSB +: FINE_W];
        end
    end

    // Delayed mode copy for mode-entry detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_prev_q <= MODE_OFF;
        else        mode_prev_q <= mode_q;
    end

    // Upper duty register.
    always_ff @(posedge clk) begin
        if (!rst_n)       duty_hi_q <= '0;
        else if (wr_duty) duty_hi_q <= reg_wdata[PER_W-1:0];
    end

    // Holding register: a capture wins over a byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_val <= '0;
        else if (cap_hit) cap_val <= tmr_cnt;
        else if (wr_lo)   cap_val[7:0] <= reg_wdata;
        else if (wr_hi)   cap_val[TMR_W-1:8] <= reg_wdata[TMR_W-9:0];
    end

    // Sticky event flag: a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 irq_flag <= 1'b0;
        else if (cap_hit || cmp_hit) irq_flag <= 1'b1;
        else if (wr_clr)            irq_flag <= 1'b0;
    end

    tcc_pin_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .rise_o(rise), .fall_o(fall)
    );

    tcc_capture #(.SHORT_DIV(4), .LONG_DIV(16)) u_cap (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .clr_i(mode_chg),
        .rise_i(rise), .fall_i(fall), .hit_o(cap_hit)
    );

    tcc_compare #(.TMR_W(TMR_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .entry_i(mode_chg),
        .tmr_i(tmr_cnt), .ref_i(cap_val), .hit_o(cmp_hit), .level_o(cmp_level)
    );

    tcc_pwm #(.PER_W(PER_W), .FINE_W(FINE_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .en_i(is_pwm(mode_q)), .per_i(per_cnt),
        .wrap_i(per_wrap), .duty_i({duty_hi_q, dc_lo_q}), .pwm_o(pwm_level)
    );

    // Pin mux: PWM, the compare latch, or idle low.
    always_comb begin
        pin_oe = drives_pin(mode_q);
        if (is_pwm(mode_q))  pin_out = pwm_level;
        else if (pin_oe)     pin_out = cmp_level;
        else                 pin_out = 1'b0;
    end

    // Register readback.
    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:   reg_rdata = {2'b00, dc_lo_q, mode_q};
            ADDR_VAL_LO: reg_rdata = cap_val[7:0];
            ADDR_VAL_HI: reg_rdata = 8'(cap_val >> 8);
            ADDR_DUTY:   reg_rdata = 8'(duty_hi_q);
            ADDR_STAT:   reg_rdata = {7'd0, irq_flag};
            default:     reg_rdata = 8'd0;
        endcase
    end
endmodule

// File: rtl/tcc_channel_chk.sv
// Property checker for tcc_channel, attached by bind below.
module tcc_channel_chk
    import tcc_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       mode_q,
    input logic             cap_hit,
    input logic             cmp_hit,
    input logic [TMR_W-1:0] tmr_cnt,
    input logic [TMR_W-1:0] cap_val,
    input logic             pin_out,
    input logic             per_wrap,
    input logic             irq_flag,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [7:0]       reg_wdata
);
    logic ctrl_wr, clr_wr, inert;
    assign ctrl_wr = reg_wr && reg_addr == ADDR_CTRL;
    assign clr_wr  = reg_wr && reg_addr == ADDR_STAT && reg_wdata[0];
    assign inert   = (mode_q == 4'b0000) || (mode_q == 4'b0001) ||
                     (mode_q == 4'b0011) || (mode_q == 4'b1011);

    a_r2_inert_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (inert && !irq_flag) |=> !irq_flag);

    a_r3_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> cap_val == $past(tmr_cnt));

    a_r5_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CMP_TOGGLE && cmp_hit && !ctrl_wr) |=> pin_out != $past(pin_out));

    a_r6_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CMP_SET && $stable(mode_q) && cmp_hit && !ctrl_wr) |=> pin_out);

    a_r6_entry_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CMP_SET && !$stable(mode_q) && !ctrl_wr) |=> !pin_out);

    a_r8_rise_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pin_out) && is_pwm(mode_q) && $stable(mode_q)) |-> $past(per_wrap));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !cap_hit && !cmp_hit) |=> !irq_flag);

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !clr_wr) |=> irq_flag);
endmodule

bind tcc_channel tcc_channel_chk #(.TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .cap_hit(cap_hit),
    .cmp_hit(cmp_hit), .tmr_cnt(tmr_cnt), .cap_val(cap_val),
    .pin_out(pin_out), .per_wrap(per_wrap), .irq_flag(irq_flag),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_tcc_channel.sv
module sim_tcc_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_cnt = '0;
    logic [7:0]  per_cnt = '0;
    logic        per_wrap = 1'b0;
    logic        pin_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        pin_out, pin_oe, irq_flag;

    always #5 clk = ~clk;

    tcc_channel u0 (
        .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .per_cnt(per_cnt),
        .per_wrap(per_wrap), .pin_in(pin_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_flag(irq_flag)
    );

    localparam int PR = 9;             // period timer top value
    localparam int PLEN = (PR + 1) * 4; // period length in clocks

    int checks = 0, errors = 0;
    bit finished = 0;
    string       q_req[$];
    logic [15:0] q_act[$], q_exp[$];

    // Driver side: push an observation and its expected value.
    task automatic push(string req, logic [15:0] act, logic [15:0] exp);
        q_req.push_back(req); q_act.push_back(act); q_exp.push_back(exp);
    endtask

    // Monitor: pop items and compare.
    initial begin
        forever begin
            @(negedge clk);
            while (q_req.size() > 0) begin
                string r; logic [15:0] a, e;
                r = q_req.pop_front(); a = q_act.pop_front(); e = q_exp.pop_front();
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", r, a, e);
                end
            end
        end
    end

    // Period timer model: steps every 4 clocks, wraps after PR.
    initial begin
        int bp = 0, bf = 0;
        forever begin
            @(negedge clk);
            if (bf == 3) begin bf = 0; bp = (bp == PR) ? 0 : bp + 1; end
            else bf++;
            per_cnt  = 8'(bp);
            per_wrap = (bf == 0 && bp == 0);
        end
    end

    task automatic wreg(logic [2:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rreg(logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic chk_val(string req, logic [15:0] exp);
        logic [7:0] lo, hi;
        rreg(3'd1, lo); rreg(3'd2, hi);
        push(req, {hi, lo}, exp);
    endtask

    task automatic chk_flag(string req, logic exp);
        logic [7:0] s;
        rreg(3'd4, s);
        push(req, {8'd0, s}, {15'd0, exp});
    endtask

    task automatic set_pin(logic v);
        @(negedge clk); pin_in = v; repeat (5) @(negedge clk);
    endtask

    task automatic rise_at(logic [15:0] t);
        @(negedge clk); tmr_cnt = t; set_pin(1'b1); set_pin(1'b0);
    endtask

    // Timer equals v for `hold` cycles, then moves away.
    task automatic match(logic [15:0] v, int hold);
        @(negedge clk); tmr_cnt = v;
        repeat (hold) @(negedge clk);
        tmr_cnt = ~v; repeat (2) @(negedge clk);
    endtask

    task automatic chk_pin(string req, logic exp_out, logic exp_oe);
        @(negedge clk);
        push(req, {14'd0, pin_oe, pin_out}, {14'd0, exp_oe, exp_out});
    endtask

    task automatic measure(output int hi);
        hi = 0;
        do @(posedge clk); while (per_wrap !== 1'b1);
        for (int i = 0; i < PLEN; i++) begin
            #1; if (pin_out) hi++;
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rreg(3'd0, d); push("R1 ctrl", {8'd0, d}, 16'h0);
        rreg(3'd3, d); push("R1 duty", {8'd0, d}, 16'h0);
        chk_val("R1 holding", 16'h0);
        chk_flag("R1 flag", 1'b0);
        chk_pin("R1 pin", 1'b0, 1'b0);

        // R10 unimplemented bits
        wreg(3'd0, 8'hF0);
        rreg(3'd0, d); push("R10 ctrl readback", {8'd0, d}, 16'h0030);

        // R3 falling capture, with dc bits set (R10 no effect)
        wreg(3'd0, 8'h34);
        @(negedge clk); tmr_cnt = 16'h1234; set_pin(1'b1);
        chk_val("R3 rising ignored in fall mode", 16'h0000);
        chk_flag("R3 no flag yet", 1'b0);
        @(negedge clk); tmr_cnt = 16'hBEEF; set_pin(1'b0);
        chk_val("R3 falling capture", 16'hBEEF);
        chk_flag("R3 capture flag", 1'b1);
        chk_flag("R11 flag sticky", 1'b1);
        wreg(3'd4, 8'h01);
        chk_flag("R11 flag cleared", 1'b0);

        // R3 rising capture
        wreg(3'd0, 8'h05);
        @(negedge clk); tmr_cnt = 16'h0A0B; set_pin(1'b1);
        chk_val("R3 rising capture", 16'h0A0B);
        @(negedge clk); tmr_cnt = 16'h1111; set_pin(1'b0);
        chk_val("R3 falling ignored in rise mode", 16'h0A0B);

        // R4 every 4th rising edge
        wreg(3'd0, 8'h06);
        for (int i = 1; i <= 3; i++) rise_at(16'(i * 16));
        chk_val("R4 no capture before 4th", 16'h0A0B);
        rise_at(16'h0040);
        chk_val("R4 capture on 4th", 16'h0040);

        // R4 mode change restarts count
        wreg(3'd0, 8'h07);
        for (int i = 0; i < 3; i++) rise_at(16'h0300 + 16'(i));
        wreg(3'd0, 8'h06);
        rise_at(16'h0311);
        chk_val("R4 count restarted on mode change", 16'h0040);
        for (int i = 0; i < 3; i++) rise_at(16'h0320 + 16'(i));
        chk_val("R4 capture after restart", 16'h0322);

        // R2 off clears prescaler, then every 16th
        wreg(3'd0, 8'h07);
        for (int i = 0; i < 5; i++) rise_at(16'h0100 + 16'(i));
        wreg(3'd0, 8'h00);
        wreg(3'd0, 8'h07);
        for (int i = 0; i < 15; i++) rise_at(16'h0200 + 16'(i));
        chk_val("R2 prescaler cleared by off", 16'h0322);
        rise_at(16'h02FF);
        chk_val("R4 capture on 16th", 16'h02FF);

        // R5 toggle
        wreg(3'd4, 8'h01);
        wreg(3'd1, 8'h00); wreg(3'd2, 8'h50);
        wreg(3'd0, 8'h32);
        repeat (2) @(negedge clk);
        chk_pin("R5 toggle idle", 1'b0, 1'b1);
        match(16'h5000, 1);
        chk_pin("R5 toggle to 1", 1'b1, 1'b1);
        chk_flag("R5 flag", 1'b1);
        match(16'h5000, 1);
        chk_pin("R5 toggle to 0", 1'b0, 1'b1);
        match(16'h5000, 4);
        chk_pin("R5 held match toggles once", 1'b1, 1'b1);

        // R6 forcing modes
        wreg(3'd0, 8'h08); repeat (2) @(negedge clk);
        chk_pin("R6 set-mode entry low", 1'b0, 1'b1);
        match(16'h5000, 1);
        chk_pin("R6 set on match", 1'b1, 1'b1);
        wreg(3'd0, 8'h09); repeat (2) @(negedge clk);
        match(16'h5000, 1);
        chk_pin("R6 clear on match", 1'b0, 1'b1);
        wreg(3'd0, 8'h08); repeat (2) @(negedge clk);
        wreg(3'd0, 8'h09); repeat (2) @(negedge clk);
        chk_pin("R6 clear-mode entry high", 1'b1, 1'b1);

        // R7 notify only
        wreg(3'd0, 8'h0A); wreg(3'd4, 8'h01);
        match(16'h5000, 1);
        chk_flag("R7 flag on match", 1'b1);
        chk_pin("R7 pin not driven", 1'b0, 1'b0);

        // R2 reserved codes inert
        foreach (q_exp[i]) ; // no-op keeps queue untouched
        for (int k = 0; k < 3; k++) begin
            logic [7:0] m;
            m = (k == 0) ? 8'h01 : (k == 1) ? 8'h03 : 8'h0B;
            wreg(3'd0, m); wreg(3'd4, 8'h01);
            match(16'h5000, 1);
            rise_at(16'h7777);
            chk_flag("R2 reserved no flag", 1'b0);
            chk_pin("R2 reserved no drive", 1'b0, 1'b0);
            chk_val("R2 reserved no capture", 16'h5000);
        end

        // R2 off clears the latch
        wreg(3'd0, 8'h08); repeat (2) @(negedge clk);
        match(16'h5000, 1);
        wreg(3'd0, 8'h00); repeat (2) @(negedge clk);
        chk_pin("R2 off releases pin", 1'b0, 1'b0);
        wreg(3'd0, 8'h02); repeat (2) @(negedge clk);
        match(16'h5000, 1);
        chk_pin("R2 latch cleared by off", 1'b1, 1'b1);

        // R8 PWM duty
        wreg(3'd3, 8'h05); wreg(3'd0, 8'h0C);
        measure(hi); measure(hi);
        push("R8 duty 20", 16'(hi), 16'd20);
        wreg(3'd0, 8'h2C); measure(hi);
        push("R8 duty 22 with low bits", 16'(hi), 16'd22);
        wreg(3'd3, 8'h03); wreg(3'd0, 8'h1F); measure(hi);
        push("R8 duty 13", 16'(hi), 16'd13);
        wreg(3'd3, 8'h00); wreg(3'd0, 8'h0C); measure(hi);
        push("R8 duty 0 low", 16'(hi), 16'd0);
        wreg(3'd3, 8'hFF); wreg(3'd0, 8'h3C); measure(hi);
        push("R8 duty max high", 16'(hi), 16'(PLEN));

        // R9 double buffering
        wreg(3'd3, 8'h05); wreg(3'd0, 8'h0C);
        measure(hi);
        wreg(3'd3, 8'h02);
        repeat (12) @(negedge clk);
        push("R9 old duty holds mid-period", {15'd0, pin_out}, 16'd1);
        measure(hi);
        push("R9 new duty next period", 16'(hi), 16'd8);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule